// File: doc/BRIEF.md
# Bus-Shared Bidirectional GPIO Port

This block is an 8-bit general-purpose I/O port whose pins are shared with the high byte of an external system bus. When the port is in I/O mode, each pin is set as an input or an output by its own direction bit. An output pin drives the value held in an output data latch. The port is controlled through a simple register interface: separate write and read strobes for the pin register, the latch register and the direction register, plus an 8-bit write data bus and an 8-bit combinational read data bus.

Reading the pin register returns the pad levels after a two-flop synchronizer. Reading the latch register returns the stored drive value, so read-modify-write sequences never pick up a pin that is being loaded externally. Writing either register loads the same latch.

Out of reset the external bus owns all eight pins. Software hands the pins over to the port by setting a bus-disable control bit. While the bus owns the pins, it supplies the drive byte and the output enables. In de-multiplexed mode it drives the high address byte at all times. In multiplexed mode it drives or releases the pins as its own output enable says. The synchronized pin byte is always returned to the bus for read data.

Top module: `gpio_busport`

## Requirements
- R1: On a clock edge with `rst_n` low, the latch clears to 0x00, the direction register sets to 0xFF (all inputs) and the bus-disable bit clears to 0, so the bus owns the pins.
- R2: In I/O mode (bus-disable bit = 1), `pin_oe[n]` is the inverse of direction bit n (1 = input, driver off; 0 = output) and `pin_out` equals the latch. For example, direction 0x03 gives `pin_oe` = 0xFC.
- R3: A write strobe on `wr_port` or on `wr_latch` loads `wdata` into the output latch at the next clock edge.
- R4: While `rd_latch` is high and `rd_port` is low, `rdata` equals the latch value.
- R5: While `rd_port` is high, `rdata` equals `pin_in` as it was two clock edges earlier (two-flop synchronizer, reset to 0), not the latch value.
- R6: `wr_dir` loads `wdata` into the direction register at the next edge. While `rd_dir` is the only read strobe, `rdata` returns the direction register. Read priority is port, then latch, then direction. With no read strobe, `rdata` is 0x00.
- R7: In bus mode, the bus fully overrides pin direction and data regardless of the latch and direction registers. Register writes are still accepted in bus mode and take effect on the pins once I/O mode is entered.
- R8: In bus mode with `bus_muxed` = 0 (de-multiplexed), `pin_oe` is 0xFF and `pin_out` equals `bus_hi`.
- R9: In bus mode with `bus_muxed` = 1, every bit of `pin_oe` equals `bus_oe` and `pin_out` equals `bus_hi`.
- R10: `bus_off` is registered. A change on it alters pin ownership only after the next clock edge.
- R11: `bus_din` always equals the synchronized pin byte, the same value a port read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_port | input | 1 | Write strobe, pin register (loads latch) |
| wr_latch | input | 1 | Write strobe, latch register |
| wr_dir | input | 1 | Write strobe, direction register |
| rd_port | input | 1 | Read strobe, synchronized pins |
| rd_latch | input | 1 | Read strobe, latch |
| rd_dir | input | 1 | Read strobe, direction register |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| bus_off | input | 1 | Bus-disable control bit value (1 = I/O mode) |
| bus_muxed | input | 1 | 1 = multiplexed address/data bus, 0 = de-multiplexed |
| bus_oe | input | 1 | Bus drive enable in multiplexed mode |
| bus_hi | input | 8 | High address or write-data byte from the bus |
| bus_din | output | 8 | Synchronized pin byte returned to the bus |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
The bench drives random mixes of write strobes, read strobes, pin levels, bus bytes and mux modes, and flips `bus_off` only occasionally. This keeps long runs in each ownership mode as well as the edges between them. Giving pins and the latch different random values separates a port read from a latch read. Random direction bytes separate per-pin enables from a whole-port enable. Directed cases cover:
- the reset values;
- register writes made while the bus owns the pins, which must stay invisible on the pads until the handover;
- the handover cycle itself, which shows the one-edge delay on `bus_off`.

// File: rtl/gpio_busport_pkg.sv
// Shared types for the bus-shared GPIO port.
// Assumes: read strobes are decoded into a single source select here.
package gpio_busport_pkg;
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_DIR  = 2'd1,
        RSEL_LAT  = 2'd2,
        RSEL_PIN  = 2'd3
    } rsel_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for the pad inputs.
// Assumes: each pin is an independent level; stages reset to 0.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // first stage captures the raw pad level
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_stage
            // each further stage re-samples the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Latch, direction and bus-disable registers of the port.
// Assumes: port and latch writes in the same cycle carry the same data.
module gpio_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_port,
    input  logic         wr_latch,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic         bus_off,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] dir_q,
    output logic         mode_q
);
    // output latch: loaded by either write path
    always_ff @(posedge clk) begin
        if (!rst_n)                   lat_q <= '0;
        else if (wr_port || wr_latch) lat_q <= wdata;
    end

    // direction register: all inputs after reset
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (wr_dir) dir_q <= wdata;
    end

    // bus-disable bit: bus owns the pins after reset
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= bus_off;
    end
endmodule

// File: rtl/gpio_padmux.sv
// Selects pad drive between the I/O registers and the external bus.
// Assumes: bus_hi already holds address or write data for the current phase.
module gpio_padmux #(
    parameter int W = 8
) (
    input  logic         io_mode,
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] dir_q,
    input  logic         bus_muxed,
    input  logic         bus_oe,
    input  logic [W-1:0] bus_hi,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    // choose owner of the pads and their enables
    always_comb begin
        if (io_mode) begin
            pin_oe  = ~dir_q;
            pin_out = lat_q;
        end else begin
            pin_oe  = bus_muxed ? {W{bus_oe}} : {W{1'b1}};
            pin_out = bus_hi;
        end
    end
endmodule

// File: rtl/gpio_busport.sv
// Top of the bus-shared 8-bit GPIO port: registers, synchronizer, pad mux
// and read-data select. Assumes a single clock domain and synchronous
// active-low reset; pin_in is asynchronous to clk.
module gpio_busport
    import gpio_busport_pkg::*;
#(
    parameter int W          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_port,
    input  logic         wr_latch,
    input  logic         wr_dir,
    input  logic         rd_port,
    input  logic         rd_latch,
    input  logic         rd_dir,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         bus_off,
    input  logic         bus_muxed,
    input  logic         bus_oe,
    input  logic [W-1:0] bus_hi,
    output logic [W-1:0] bus_din,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    logic [W-1:0] lat_q;
    logic [W-1:0] dir_q;
    logic         mode_q;
    logic [W-1:0] pin_sync;
    rsel_e        rsel;

    gpio_regs #(.W(W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_port(wr_port), .wr_latch(wr_latch), .wr_dir(wr_dir),
        .wdata(wdata), .bus_off(bus_off),
        .lat_q(lat_q), .dir_q(dir_q), .mode_q(mode_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_DEPTH)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_padmux #(.W(W)) mux_i (
        .io_mode(mode_q), .lat_q(lat_q), .dir_q(dir_q),
        .bus_muxed(bus_muxed), .bus_oe(bus_oe), .bus_hi(bus_hi),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // decode read strobes by priority: port, latch, direction
    always_comb begin
        if (rd_port)       rsel = RSEL_PIN;
        else if (rd_latch) rsel = RSEL_LAT;
        else if (rd_dir)   rsel = RSEL_DIR;
        else               rsel = RSEL_NONE;
    end

    // drive read data from the selected source
    always_comb begin
        case (rsel)
            RSEL_PIN: rdata = pin_sync;
            RSEL_LAT: rdata = lat_q;
            RSEL_DIR: rdata = dir_q;
            default:  rdata = '0;
        endcase
    end

    assign bus_din = pin_sync;
endmodule

// File: rtl/gpio_busport_chk.sv
// Assertion checker for gpio_busport, attached by bind below.
// Assumes: it sees the top's ports and internal register outputs.
module gpio_busport_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_port,
    input logic         wr_latch,
    input logic [W-1:0] wdata,
    input logic         rd_port,
    input logic         bus_off,
    input logic         bus_muxed,
    input logic [W-1:0] bus_hi,
    input logic [W-1:0] bus_din,
    input logic [W-1:0] rdata,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] lat_q,
    input logic [W-1:0] dir_q,
    input logic         mode_q
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (lat_q == '0 && dir_q == '1 && !mode_q));

    p_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (pin_oe == ~dir_q && pin_out == lat_q));

    p_latch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_port || wr_latch) |=> lat_q == $past(wdata));

    p_port_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_port |-> rdata == bus_din);

    p_demux_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !bus_muxed) |-> (pin_oe == '1 && pin_out == bus_hi));

    p_mode_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mode_q == $past(bus_off));
endmodule

bind gpio_busport gpio_busport_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_port(wr_port), .wr_latch(wr_latch),
    .wdata(wdata), .rd_port(rd_port), .bus_off(bus_off),
    .bus_muxed(bus_muxed), .bus_hi(bus_hi), .bus_din(bus_din),
    .rdata(rdata), .pin_oe(pin_oe), .pin_out(pin_out),
    .lat_q(lat_q), .dir_q(dir_q), .mode_q(mode_q)
);

// File: tb/gpio_busport_tb.sv
// Self-checking bench: random stimulus with a fixed seed plus directed cases.
module gpio_busport_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_port = 0, wr_latch = 0, wr_dir = 0;
    logic       rd_port = 0, rd_latch = 0, rd_dir = 0;
    logic [7:0] wdata = 0, bus_hi = 0, pin_in = 0;
    logic       bus_off = 0, bus_muxed = 0, bus_oe = 0;
    logic [7:0] rdata, bus_din, pin_oe, pin_out;

    int total = 0;
    int bad = 0;

    // bench model state
    logic [7:0] m_lat, m_dir, m_s1, m_s2;
    logic       m_mode;

    always #10 clk = ~clk;

    gpio_busport dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_port(wr_port), .wr_latch(wr_latch), .wr_dir(wr_dir),
        .rd_port(rd_port), .rd_latch(rd_latch), .rd_dir(rd_dir),
        .wdata(wdata), .rdata(rdata),
        .bus_off(bus_off), .bus_muxed(bus_muxed), .bus_oe(bus_oe),
        .bus_hi(bus_hi), .bus_din(bus_din),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // model update at the same edge the design registers
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = 8'h00; m_dir = 8'hFF; m_mode = 1'b0; m_s1 = 0; m_s2 = 0;
        end else begin
            if (wr_port || wr_latch) m_lat = wdata;
            if (wr_dir) m_dir = wdata;
            m_mode = bus_off;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    function automatic logic [7:0] exp_oe();
        if (m_mode) return ~m_dir;
        return bus_muxed ? {8{bus_oe}} : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_out();
        return m_mode ? m_lat : bus_hi;
    endfunction

    function automatic logic [7:0] exp_rd();
        if (rd_port)  return m_s2;
        if (rd_latch) return m_lat;
        if (rd_dir)   return m_dir;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // compare every output against the model
    task automatic chk_all();
        string rq;
        rq = m_mode ? "R2" : (bus_muxed ? "R9" : "R8");
        chk(rq, "pin_oe", pin_oe, exp_oe());
        chk(rq, "pin_out", pin_out, exp_out());
        rq = rd_port ? "R5" : (rd_latch ? "R4" : "R6");
        chk(rq, "rdata", rdata, exp_rd());
        chk("R11", "bus_din", bus_din, m_s2);
    endtask

    task automatic idle();
        {wr_port, wr_latch, wr_dir, rd_port, rd_latch, rd_dir} = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset values
        idle(); rd_latch = 1; #1 chk("R1", "latch after reset", rdata, 8'h00);
        rd_latch = 0; rd_dir = 1; #1 chk("R1", "dir after reset", rdata, 8'hFF);
        rd_dir = 0; bus_muxed = 0; #1 chk("R1", "bus owns pins", pin_oe, 8'hFF);
        // R7: writes in bus mode invisible on pins
        wdata = 8'h03; wr_dir = 1; bus_hi = 8'hA5;
        @(negedge clk); idle(); wdata = 8'h5A; wr_latch = 1;
        @(negedge clk); idle();
        #1 chk("R7", "bus pins still bus oe", pin_oe, 8'hFF);
        chk("R7", "bus pins still bus data", pin_out, 8'hA5);
        // R10: handover only after the next edge
        bus_off = 1; #1 chk("R10", "before edge", pin_out, 8'hA5);
        @(negedge clk);
        chk("R10", "after edge oe", pin_oe, 8'hFC);
        chk("R2", "dir 0x03 gives oe FC", pin_oe, 8'hFC);
        chk("R7", "bus-mode write now on pins", pin_out, 8'h5A);
        // R3: port write loads latch
        wdata = 8'hC3; wr_port = 1;
        @(negedge clk); idle(); rd_latch = 1;
        #1 chk("R3", "port write to latch", rdata, 8'hC3);
        // R5: port read differs from latch
        rd_latch = 0; pin_in = 8'h3C; rd_port = 1;
        @(negedge clk); chk("R5", "one edge not yet", rdata, 8'h00);
        @(negedge clk); chk("R5", "two edges", rdata, 8'h3C);
        // R6: priority latch over direction, none gives zero
        rd_port = 0; rd_latch = 1; rd_dir = 1;
        #1 chk("R6", "latch over dir", rdata, 8'hC3);
        idle(); #1 chk("R6", "no strobe", rdata, 8'h00);
        // random phase
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            wr_port  = ($urandom % 6) == 0;
            wr_latch = ($urandom % 6) == 0;
            wr_dir   = ($urandom % 6) == 0;
            rd_port  = ($urandom % 3) == 0;
            rd_latch = ($urandom % 3) == 0;
            rd_dir   = ($urandom % 3) == 0;
            wdata    = 8'($urandom);
            pin_in   = 8'($urandom);
            bus_hi   = 8'($urandom);
            bus_oe   = $urandom % 2;
            bus_muxed = $urandom % 2;
            if (($urandom % 16) == 0) bus_off = ~bus_off;
            #1 chk_all();
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule